// File: doc/BRIEF.md
# Phase-Correct PWM Timer Channel

This block is a dual-slope timer for waveform generation. A counter of `CNT_W` bits climbs from zero to a selectable limit and then falls back to zero, one step per prescaled tick. Two compare channels watch the count and drive their outputs. The output changes in one direction when the count passes the compare value on the way up, and in the other direction on the way down. The pulses are therefore centred in each period, and the period lasts `2 * N * limit` clocks, where N is the prescale ratio.

Software programs the block through a single-cycle write port. The port reaches a control word, the counter, two compare buffers, a limit register and a write-one-to-clear flag register. The limit comes from one of three sources: a fixed width of 8, 9 or 10 bits, the limit register, or the live compare value of channel A. Compare values are buffered and take effect only when the count reaches the limit. Because of this, a limit change made while the timer runs gives a period whose falling half uses the old limit and whose rising half uses the new one.

Top module: `pcpwm_timer`

Write map (`wr_addr`): 0 control, 1 counter, 2 compare A buffer, 3 compare B buffer, 4 limit register, 5 flag clear. The control word is laid out as follows:
- Bits [2:0] select the limit source.
- Bits [5:3] select the prescaler.
- Bits [7:6] hold the output mode of channel A.
- Bits [9:8] hold the output mode of channel B.

## Requirements
- R1: After reset the counter is 0 and heading up. On each tick it moves by one: up until it reaches the limit, then down until it reaches 0. Each extreme is held for exactly one tick per pass. For a limit T, the count after k ticks from 0 is k mod 2T when that value is ≤ T, and 2T − (k mod 2T) otherwise. A limit of 0 holds the count at 0.
- R2: Prescaler field code 1 gives a tick every clock, 2 every 8 clocks, 3 every 64, 4 every 256 and 5 every 1024. Codes 0, 6 and 7 stop the counter.
- R3: `flag_ovf` is set in the same cycle the count steps down to 0. Writing 1 to bit 0 at address 5 clears it.
- R4: Limit source code 0 gives a limit of 255, code 1 gives 511 and code 2 gives 1023. Code 4 uses the live compare A value. Codes 3, 5, 6 and 7 use the limit register.
- R5: Compare writes land in a buffer. The buffer moves to the live compare value in the cycle the count steps up to the limit. In that same cycle, `flag_cmpa` is set when the source is code 4, and `flag_topreg` is set when the source is the limit register. Writing 1 to bit 1 or bit 2 at address 5 clears the matching flag.
- R6: Mode 2 (non-inverted) drives the output low when the count rises onto the compare value C, and high when it falls onto C. In steady state the output is high for 2C of every 2T ticks.
- R7: Mode 3 (inverted) drives the levels opposite to mode 2.
- R8: In mode 2, C = 0 keeps the output low and C = T keeps it high. Mode 3 gives the opposite levels.
- R9: Mode 1 on channel A, with limit source code 4, toggles the output each time the count reaches the limit. Mode 1 in any other setting, and mode 0 always, drive the output low.
- R10: With a fixed-width limit selected, a compare write clears the data bits above the selected width.
- R11: A live compare value above the limit never matches, so the output keeps its level.
- R12: A counter write replaces the count without a step. The tick right after the write makes no compare match.
- R13: A new compare A value written while compare A sets the limit takes effect at the next limit. The falling slope after that point keeps the old length, and the following rising slope has the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write target, see map |
| wr_data | input | CNT_W | Write data |
| cnt_o | output | CNT_W | Current count |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| flag_ovf | output | 1 | Count reached zero |
| flag_cmpa | output | 1 | Limit reached while compare A is the limit |
| flag_topreg | output | 1 | Limit reached while the limit register is the limit |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, a 10-bit prescaler and a 3-bit address. These defaults make the 1024 ratio and all three fixed widths reachable. The bench keeps most periods short by using small limits from the limit register or compare A, which makes several full periods, toggles and slope-length measurements affordable. One test walks up to the 8-bit fixed limit of 255 to check masking and the turn at a fixed limit.

// File: rtl/pcpwm_pkg.sv
// Shared constants, output-mode encoding and prescale decode for the
// phase-correct PWM timer. Assumes a control word of CTRL_W bits.
package pcpwm_pkg;
    localparam int CTRL_W = 10;

    // write map
    localparam int A_CTRL  = 0;
    localparam int A_CNT   = 1;
    localparam int A_CMPA  = 2;
    localparam int A_TOPR  = 4;
    localparam int A_FLAGS = 5;

    // limit source codes
    localparam logic [2:0] TS_FIX8  = 3'd0;
    localparam logic [2:0] TS_FIX9  = 3'd1;
    localparam logic [2:0] TS_FIX10 = 3'd2;
    localparam logic [2:0] TS_CMPA  = 3'd4;

    typedef enum logic [1:0] {
        OM_OFF    = 2'd0,
        OM_TOGGLE = 2'd1,
        OM_NONINV = 2'd2,
        OM_INV    = 2'd3
    } out_mode_e;

    // clocks per tick for a prescaler code; 0 means stopped
    function automatic int unsigned presc_div(input logic [2:0] sel);
        case (sel)
            3'd1:    return 1;
            3'd2:    return 8;
            3'd3:    return 64;
            3'd4:    return 256;
            3'd5:    return 1024;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/pcpwm_prescaler.sv
// Tick generator. Produces a one-cycle tick every N clocks for the selected
// ratio, and none while stopped. Assumes PRE_W bits can hold 1023.
module pcpwm_prescaler import pcpwm_pkg::*; #(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [PRE_W-1:0] pcnt;
    int unsigned      div;
    logic             running;

    // decode ratio and detect the last clock of a tick window
    always_comb begin
        div     = presc_div(sel);
        running = (div != 0);
        tick    = running && (pcnt == PRE_W'(div - 1));
    end

    // advance the divide counter, restarting on a tick or when stopped
    always_ff @(posedge clk) begin
        if (!rst_n)                pcnt <= '0;
        else if (!running || tick) pcnt <= '0;
        else                       pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/pcpwm_counter.sv
// Dual-slope counter. Steps toward the limit, turns there, falls to zero,
// and turns again. Reports the next value, the step direction and the arrival
// events so that the rest of the timer acts on the same edge. A load replaces
// the count without a step and arms a one-tick match suppression.
module pcpwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] top,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] nxt,
    output logic             step_up,
    output logic             step_ok,
    output logic             match_ok,
    output logic             evt_top,
    output logic             evt_bot,
    output logic             skip
);
    logic dir_up, dir_nxt;

    // choose the next count and the direction of this step
    always_comb begin
        if (top == '0) begin
            nxt = '0;            step_up = 1'b1;
        end else if (dir_up && cnt < top) begin
            nxt = cnt + 1'b1;    step_up = 1'b1;
        end else if (dir_up) begin
            nxt = cnt - 1'b1;    step_up = 1'b0;
        end else if (cnt == '0) begin
            nxt = cnt + 1'b1;    step_up = 1'b1;
        end else begin
            nxt = cnt - 1'b1;    step_up = 1'b0;
        end
        dir_nxt  = step_up ? (nxt < top) : (nxt == '0);
        step_ok  = tick && !ld_en;
        match_ok = step_ok && !skip;
        evt_top  = step_up && (nxt == top);
        evt_bot  = !step_up && (nxt == '0);
    end

    // hold count, direction and suppression state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0; dir_up <= 1'b1; skip <= 1'b0;
        end else if (ld_en) begin
            cnt <= ld_val; skip <= 1'b1;
        end else if (tick) begin
            cnt <= nxt; dir_up <= dir_nxt; skip <= 1'b0;
        end
    end
endmodule

// File: rtl/pcpwm_wave.sv
// One compare channel. On a match (the count steps onto the live compare
// value) it sets, clears or toggles its output level according to the mode.
// A compare equal to the limit forces the active level, and a compare of zero
// forces the idle level.
module pcpwm_wave import pcpwm_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  out_mode_e        mode,
    input  logic             toggle_ok,
    input  logic             match_ok,
    input  logic             step_up,
    input  logic [CNT_W-1:0] nxt,
    input  logic [CNT_W-1:0] cmp,
    input  logic [CNT_W-1:0] top,
    output logic             wave_o
);
    logic hit, lvl, level;

    // match detect and the non-inverted level a match selects
    always_comb begin
        hit = match_ok && (nxt == cmp);
        if (cmp == top)      lvl = 1'b1;
        else if (cmp == '0)  lvl = 1'b0;
        else                 lvl = !step_up;
    end

    // update the output register on a match
    always_ff @(posedge clk) begin
        if (!rst_n) level <= 1'b0;
        else if (hit) begin
            case (mode)
                OM_TOGGLE: if (toggle_ok) level <= !level;
                OM_NONINV: level <= lvl;
                OM_INV:    level <= !lvl;
                default:   level <= level;
            endcase
        end
    end

    // disconnect the output in unused modes
    assign wave_o = ((mode == OM_NONINV) || (mode == OM_INV) ||
                     (mode == OM_TOGGLE && toggle_ok)) ? level : 1'b0;
endmodule

// File: rtl/pcpwm_timer.sv
// Phase-correct PWM timer top. Holds the programmable registers, selects the
// limit, double-buffers the compare values and keeps the event flags.
// Assumes CNT_W >= 10 so that the control word and fixed limits fit.
module pcpwm_timer import pcpwm_pkg::*; #(
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 10,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              wave_a,
    output logic              wave_b,
    output logic              flag_ovf,
    output logic              flag_cmpa,
    output logic              flag_topreg
);
    localparam int NCH = 2;

    logic [CTRL_W-1:0] ctrl;
    logic [2:0]        top_sel, clk_sel;
    logic [1:0]        ch_mode [NCH];
    logic [CNT_W-1:0]  top_reg, res_mask, top_eff;
    logic              fixed_top;
    logic [CNT_W-1:0]  cmp_buf [NCH];
    logic [CNT_W-1:0]  cmp_act [NCH];
    logic [NCH-1:0]    wave_vec;
    logic              tick, cnt_wr, cnt_skip, step_up, step_ok, match_ok;
    logic              evt_top, evt_bot;
    logic [CNT_W-1:0]  cnt_nxt;

    assign top_sel    = ctrl[2:0];
    assign clk_sel    = ctrl[5:3];
    assign ch_mode[0] = ctrl[7:6];
    assign ch_mode[1] = ctrl[9:8];
    assign cnt_wr     = wr_en && (wr_addr == ADDR_W'(A_CNT));

    // limit selection and the resolution mask for fixed limits
    always_comb begin
        fixed_top = (top_sel == TS_FIX8) || (top_sel == TS_FIX9) || (top_sel == TS_FIX10);
        case (top_sel)
            TS_FIX8:  res_mask = CNT_W'(32'h0000_00FF);
            TS_FIX9:  res_mask = CNT_W'(32'h0000_01FF);
            TS_FIX10: res_mask = CNT_W'(32'h0000_03FF);
            default:  res_mask = '1;
        endcase
        if (fixed_top)              top_eff = res_mask;
        else if (top_sel == TS_CMPA) top_eff = cmp_act[0];
        else                        top_eff = top_reg;
    end

    pcpwm_prescaler #(.PRE_W(PRE_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .sel(clk_sel), .tick(tick)
    );

    pcpwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .top(top_eff),
        .ld_en(cnt_wr), .ld_val(wr_data), .cnt(cnt_o), .nxt(cnt_nxt),
        .step_up(step_up), .step_ok(step_ok), .match_ok(match_ok),
        .evt_top(evt_top), .evt_bot(evt_bot), .skip(cnt_skip)
    );

    // control word and limit register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0; top_reg <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(A_CTRL)) ctrl    <= wr_data[CTRL_W-1:0];
            if (wr_addr == ADDR_W'(A_TOPR)) top_reg <= wr_data;
        end
    end

    // compare buffers take masked writes; live values load at the limit
    always_ff @(posedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (!rst_n) begin
                cmp_buf[i] <= '0; cmp_act[i] <= '0;
            end else begin
                if (wr_en && wr_addr == ADDR_W'(A_CMPA + i))
                    cmp_buf[i] <= wr_data & (fixed_top ? res_mask : '1);
                if (step_ok && evt_top)
                    cmp_act[i] <= cmp_buf[i];
            end
        end
    end

    // event flags: set on events, cleared by writing ones; set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_ovf <= 1'b0; flag_cmpa <= 1'b0; flag_topreg <= 1'b0;
        end else begin
            if (wr_en && wr_addr == ADDR_W'(A_FLAGS)) begin
                if (wr_data[0]) flag_ovf    <= 1'b0;
                if (wr_data[1]) flag_cmpa   <= 1'b0;
                if (wr_data[2]) flag_topreg <= 1'b0;
            end
            if (step_ok && evt_bot) flag_ovf <= 1'b1;
            if (step_ok && evt_top && top_sel == TS_CMPA) flag_cmpa <= 1'b1;
            if (step_ok && evt_top && !fixed_top && top_sel != TS_CMPA) flag_topreg <= 1'b1;
        end
    end

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        localparam bit IS_A = (gi == 0);
        pcpwm_wave #(.CNT_W(CNT_W)) u_wave (
            .clk(clk), .rst_n(rst_n), .mode(out_mode_e'(ch_mode[gi])),
            .toggle_ok(IS_A && (top_sel == TS_CMPA)), .match_ok(match_ok),
            .step_up(step_up), .nxt(cnt_nxt), .cmp(cmp_act[gi]),
            .top(top_eff), .wave_o(wave_vec[gi])
        );
    end

    assign wave_a = wave_vec[0];
    assign wave_b = wave_vec[1];
endmodule

// File: rtl/pcpwm_timer_chk.sv
// Assertion checker bound into the timer top. Relates the counter, waveform
// and flag outputs to the tick, write and suppression state across cycles.
module pcpwm_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             tick,
    input logic             cnt_wr,
    input logic             skip,
    input logic [CNT_W-1:0] top_val,
    input logic [CNT_W-1:0] cnt_o,
    input logic             wave_a,
    input logic             wave_b,
    input logic             flag_ovf,
    input logic             flag_cmpa,
    input logic             flag_topreg
);
    AST_CNT_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr) |=> (cnt_o == $past(cnt_o) + 1'b1 || cnt_o == $past(cnt_o) - 1'b1 ||
                               (cnt_o == '0 && $past(cnt_o) == '0))); // R1
    AST_CNT_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(cnt_o)); // R2
    AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_ovf) |-> (cnt_o == '0)); // R3
    AST_CMPA_FLAG_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_cmpa) |-> (cnt_o == $past(top_val))); // R5
    AST_TOPREG_FLAG_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_topreg) |-> (cnt_o == $past(top_val))); // R5
    AST_WAVE_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> ($stable(wave_a) && $stable(wave_b))); // R6
    AST_NO_MATCH_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (skip && !wr_en) |=> ($stable(wave_a) && $stable(wave_b))); // R12
endmodule

bind pcpwm_timer pcpwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tick(tick), .cnt_wr(cnt_wr),
    .skip(cnt_skip), .top_val(top_eff), .cnt_o(cnt_o), .wave_a(wave_a),
    .wave_b(wave_b), .flag_ovf(flag_ovf), .flag_cmpa(flag_cmpa),
    .flag_topreg(flag_topreg)
);

// File: tb/pcpwm_timer_tb.sv
`timescale 1ns/1ps
module pcpwm_timer_tb;
    localparam int CNT_W = 16;
    localparam int ADDR_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [CNT_W-1:0]  wr_data = '0;
    logic [CNT_W-1:0]  cnt_o;
    logic              wave_a, wave_b, flag_ovf, flag_cmpa, flag_topreg;
    int                n_chk = 0;
    int                n_fail = 0;

    always #2.5 clk = ~clk;

    pcpwm_timer #(.CNT_W(CNT_W), .PRE_W(10), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cnt_o(cnt_o), .wave_a(wave_a), .wave_b(wave_b),
        .flag_ovf(flag_ovf), .flag_cmpa(flag_cmpa), .flag_topreg(flag_topreg)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [CNT_W-1:0] ctl(input int tsel, input int csel, input int ma, input int mb);
        return CNT_W'((mb << 8) | (ma << 6) | (csel << 3) | tsel);
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input int addr, input logic [CNT_W-1:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cnt(input int val, input int lim, output int n);
        n = 0;
        while (int'(cnt_o) != val && n < lim) begin
            @(negedge clk); n++;
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "reset count", int'(cnt_o), 0);
        chk("R1", "reset waves", int'({wave_a, wave_b}), 0);
        chk("R3", "reset flags", int'({flag_ovf, flag_cmpa, flag_topreg}), 0);
    endtask

    task automatic t_triangle();
        int exp, m;
        do_reset();
        wr(4, 16'd5);
        wr(0, ctl(3, 1, 0, 0));
        for (int k = 0; k <= 12; k++) begin
            m = k % 10;
            exp = (m <= 5) ? m : 10 - m;
            chk("R1", "triangle count", int'(cnt_o), exp);
            if (k == 4)  chk("R5", "limit flag before limit", int'(flag_topreg), 0);
            if (k == 5)  chk("R5", "limit flag at limit", int'(flag_topreg), 1);
            if (k == 9)  chk("R3", "ovf before zero", int'(flag_ovf), 0);
            if (k == 10) chk("R3", "ovf at zero", int'(flag_ovf), 1);
            if (k < 12) @(negedge clk);
        end
        chk("R5", "cmpa flag idle with limit reg", int'(flag_cmpa), 0);
        wr(5, 16'h0007);
        chk("R3", "ovf cleared by one", int'(flag_ovf), 0);
        chk("R5", "limit flag cleared by one", int'(flag_topreg), 0);
    endtask

    task automatic t_presc();
        int n, v;
        do_reset();
        wr(4, 16'd100);
        wr(0, ctl(3, 2, 0, 0));
        wait_cnt(1, 100, n);
        wait_cnt(2, 100, n);
        chk("R2", "ratio 8 spacing", n, 8);
        wr(0, ctl(3, 5, 0, 0));
        wait_cnt(4, 3000, n);
        wait_cnt(5, 3000, n);
        chk("R2", "ratio 1024 spacing", n, 1024);
        wr(0, ctl(3, 0, 0, 0));
        v = int'(cnt_o);
        repeat (50) @(negedge clk);
        chk("R2", "code 0 stopped", int'(cnt_o), v);
        wr(0, ctl(3, 6, 0, 0));
        repeat (50) @(negedge clk);
        chk("R2", "code 6 stopped", int'(cnt_o), v);
    endtask

    task automatic t_fixed8();
        int n;
        do_reset();
        wr(3, 16'h1F05);
        wr(0, ctl(0, 1, 0, 2));
        wait_cnt(255, 400, n);
        chk("R4", "reached fixed 8-bit limit", int'(cnt_o), 255);
        @(negedge clk);
        chk("R4", "turned after fixed limit", int'(cnt_o), 254);
        chk("R5", "no reg flags on fixed limit", int'({flag_cmpa, flag_topreg}), 0);
        wait_cnt(3, 400, n);
        chk("R10", "masked compare matched", int'(wave_b), 1);
    endtask

    task automatic t_pwm();
        int n, highs;
        do_reset();
        wr(4, 16'd10);
        wr(2, 16'd4);
        wr(3, 16'd4);
        wr(0, ctl(3, 1, 2, 3));
        wait_cnt(10, 100, n);
        wait_cnt(3, 100, n);
        highs = 0;
        for (int k = 0; k < 40; k++) begin
            if (cnt_o < 16'd4) begin
                chk("R6", "noninv low count", int'(wave_a), 1);
                chk("R7", "inv low count", int'(wave_b), 0);
            end else if (cnt_o > 16'd4) begin
                chk("R6", "noninv high count", int'(wave_a), 0);
                chk("R7", "inv high count", int'(wave_b), 1);
            end
            if (k < 20 && wave_a) highs++;
            @(negedge clk);
        end
        chk("R6", "duty over one period", highs, 8);
    endtask

    task automatic t_extreme();
        int n;
        do_reset();
        wr(4, 16'd10);
        wr(2, 16'd0);
        wr(3, 16'd10);
        wr(0, ctl(3, 1, 2, 2));
        wait_cnt(10, 100, n);
        wait_cnt(0, 100, n);
        wait_cnt(10, 100, n);
        for (int k = 0; k < 40; k++) begin
            chk("R8", "compare zero stays low", int'(wave_a), 0);
            chk("R8", "compare limit stays high", int'(wave_b), 1);
            @(negedge clk);
        end
    endtask

    task automatic t_above();
        int n;
        do_reset();
        wr(4, 16'd10);
        wr(2, 16'd15);
        wr(3, 16'd15);
        wr(0, ctl(3, 1, 2, 3));
        wait_cnt(10, 100, n);
        for (int k = 0; k < 60; k++) begin
            chk("R11", "no match above limit", int'({wave_a, wave_b}), 0);
            @(negedge clk);
        end
    endtask

    task automatic t_toggle();
        int n, v1;
        do_reset();
        wr(2, 16'd6);
        wr(3, 16'd3);
        wr(0, ctl(4, 1, 1, 0));
        wait_cnt(6, 100, n);
        chk("R5", "cmpa flag at limit", int'(flag_cmpa), 1);
        chk("R5", "reg flag idle with cmpa limit", int'(flag_topreg), 0);
        v1 = int'(wave_a);
        wait_cnt(0, 100, n);
        chk("R9", "toggle holds between limits", int'(wave_a), v1);
        chk("R9", "mode 0 low", int'(wave_b), 0);
        wait_cnt(6, 100, n);
        chk("R9", "toggle at limit", int'(wave_a), 1 - v1);
        wait_cnt(0, 100, n);
        wait_cnt(6, 100, n);
        chk("R9", "toggle back at limit", int'(wave_a), v1);
        do_reset();
        wr(4, 16'd10);
        wr(2, 16'd5);
        wr(3, 16'd5);
        wr(0, ctl(3, 1, 1, 1));
        for (int k = 0; k < 40; k++) begin
            chk("R9", "mode 1 without cmpa limit low", int'({wave_a, wave_b}), 0);
            @(negedge clk);
        end
    endtask

    task automatic t_suppress();
        int n;
        do_reset();
        wr(4, 16'd10);
        wr(3, 16'd5);
        wr(0, ctl(3, 1, 0, 2));
        wait_cnt(10, 100, n);
        wait_cnt(8, 100, n);
        wr(1, 16'd6);
        chk("R12", "count replaced by write", int'(cnt_o), 6);
        wait_cnt(4, 100, n);
        chk("R12", "match after write suppressed", int'(wave_b), 0);
    endtask

    task automatic t_asym();
        int n;
        do_reset();
        wr(2, 16'd10);
        wr(0, ctl(4, 1, 0, 0));
        wait_cnt(10, 100, n);
        wr(2, 16'd6);
        wait_cnt(10, 100, n);
        wait_cnt(0, 100, n);
        chk("R13", "falling slope keeps old length", n, 10);
        wait_cnt(6, 100, n);
        chk("R13", "rising slope has new length", n, 6);
        @(negedge clk);
        chk("R13", "turns at new limit", int'(cnt_o), 5);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_triangle();
        t_presc();
        t_fixed8();
        t_pwm();
        t_extreme();
        t_above();
        t_toggle();
        t_suppress();
        t_asym();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule